// File: doc/BRIEF.md
# Save-Frame Stack Manager

This block keeps track of a stack of equal-sized save frames that belong to one protected execution thread. The thread carries a current frame index (how many frames are occupied) and a frame count (how many frames exist). When a resume is requested, the block works out where the topmost occupied frame lives in the linear address space and where its register area sits at the tail of that frame. It also computes the 16-byte shadow-stack save slot that belongs to the frame, picks the instruction address at which execution continues, and produces the index value to write back.

Two resume flavours exist. In a plain resume the topmost frame is popped: execution continues at the instruction pointer saved in that frame and the index drops by one. When the thread has notification enabled and the saved register area flags a pending notification, the block instead prepares a fresh entry into the next free frame. That frame must exist. The target becomes the entry offset relocated by the enclave base, the index is left as it is, and its value is handed out as a result for the entered code.

All results are registered: a one-cycle `start` pulse presents the operands, and one cycle later `done` pulses with the results. The results then hold until the next start. An index write-back strobe accompanies `done` only when no fault was found.

Top module: `frame_stack_mgr`

## Requirements
- R1: A current index of 0 (no occupied frame) raises a fault with `fault_code` = 1.
- R2: Without notification, `frame_addr` = area offset + enclave base + 4096 × frame pages × (index − 1), all modulo 2^64.
- R3: `regs_addr` = `frame_addr` + 4096 × frame pages − REG_AREA_BYTES (default 184).
- R4: Notification is taken only when `notify_en` is 1 and bit 0 of `notify_byte` is 1; the other bits of the byte have no effect.
- R5: On notification, an index greater than or equal to the frame count raises a fault with `fault_code` = 2.
- R6: On notification, `frame_addr` advances by one frame (factor = index), `target` = entry offset + enclave base, `new_idx` equals the current index and `ret_idx` carries the current index.
- R7: Without notification, `target` is the saved instruction pointer, `new_idx` is the index minus 1, and `ret_idx` is 0.
- R8: `shadow_addr` = shadow offset + enclave base + 16 × slot, where slot is the index on notification and index − 1 otherwise.
- R9: A shadow offset whose low 4 bits are not all zero raises a fault with `fault_code` = 4.
- R10: With `mode64` = 1, a target whose bits 63..47 are not all equal raises a fault with `fault_code` = 3.
- R11: With `mode64` = 0, a target above the zero-extended `cs_limit` raises a fault with `fault_code` = 3.
- R12: When several faults apply, the smallest code is reported (1 before 2 before 3 before 4); `fault_code` is 0 when there is no fault.
- R13: `done` pulses exactly one cycle after `start`, and results hold until the next start. `idx_we` pulses with `done` only when `fault` is 0. After reset, `done`, `fault`, `idx_we` and `fault_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request; operands sampled on this cycle |
| area_off | input | 64 | Offset of the frame area inside the enclave |
| encl_base | input | 64 | Enclave base linear address |
| frame_pages | input | 16 | Frame size in 4 KiB pages |
| cur_idx | input | 32 | Current frame index (occupied frames) |
| frame_cnt | input | 32 | Number of frames available |
| notify_en | input | 1 | Thread-level notification enable |
| notify_byte | input | 8 | Notification byte read from the saved register area |
| entry_off | input | 64 | Entry point offset inside the enclave |
| saved_ip | input | 64 | Instruction pointer saved in the topmost frame |
| shadow_off | input | 64 | Offset of the shadow-stack save slots |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| cs_limit | input | 32 | Code-segment limit used in 32-bit mode |
| done | output | 1 | Result valid pulse, one cycle after start |
| fault | output | 1 | Request faulted |
| fault_code | output | 3 | 0 none, 1 no frame, 2 no room, 3 bad target, 4 slot misaligned |
| notify_taken | output | 1 | Notification path chosen |
| frame_addr | output | 64 | Linear address of the selected frame |
| regs_addr | output | 64 | Linear address of the register area in that frame |
| shadow_addr | output | 64 | Linear address of the shadow-stack save slot |
| target | output | 64 | Resume instruction address |
| new_idx | output | 32 | Index value to write back |
| idx_we | output | 1 | Write-back strobe, only on a fault-free result |
| ret_idx | output | 32 | Index handed to the entered code on notification, else 0 |

## Verification
The notify-path bound check and the target check can both fail on one request: a notification request whose index equals the frame count and whose relocated entry point is non-canonical or above the code limit. The bench provokes this, adds a misaligned shadow offset and a zero index on top in further cases, and judges that only the lowest code appears and that no write-back strobe is raised. The full sweep also covers the plain-pop and notify-entry paths against each other for every index/count pair of a small configuration.

// File: rtl/frame_stack_pkg.sv
// Package: shared widths and fault codes of the save-frame stack manager.
// Assumes 4 KiB pages and a 16-byte shadow-stack save slot stride.
package frame_stack_pkg;
    localparam int ADDR_W     = 64;
    localparam int IDX_W      = 32;
    localparam int PAGES_W    = 16;
    localparam int PAGE_SHIFT = 12;
    localparam int SLOT_SHIFT = 4;

    typedef enum logic [2:0] {
        FC_NONE     = 3'd0,
        FC_NO_FRAME = 3'd1,
        FC_NO_ROOM  = 3'd2,
        FC_TARGET   = 3'd3,
        FC_MISALIGN = 3'd4
    } fault_code_e;
endpackage

// File: rtl/fs_addr_calc.sv
// Address generator: frame, register-area and shadow-slot addresses.
// Assumes all arithmetic wraps modulo 2^AW; the slot index already
// reflects the notify decision made by the caller.
module fs_addr_calc #(
    parameter int AW        = 64,
    parameter int IW        = 32,
    parameter int PW        = 16,
    parameter int PG_SHIFT  = 12,
    parameter int SL_SHIFT  = 4,
    parameter int REG_BYTES = 184
) (
    input  logic [AW-1:0] area_off,
    input  logic [AW-1:0] encl_base,
    input  logic [PW-1:0] frame_pages,
    input  logic [IW-1:0] slot_idx,
    input  logic [AW-1:0] shadow_off,
    output logic [AW-1:0] frame_addr,
    output logic [AW-1:0] regs_addr,
    output logic [AW-1:0] shadow_addr
);
    localparam logic [AW-1:0] REG_SZ = AW'(REG_BYTES);

    logic [AW-1:0] stride;
    logic [AW-1:0] idx_ext;

    // Frame stride in bytes and the zero-extended slot index.
    always_comb begin
        stride  = AW'(frame_pages) << PG_SHIFT;
        idx_ext = AW'(slot_idx);
    end

    // Frame base, register area at the frame tail, shadow slot.
    always_comb begin
        frame_addr  = area_off + encl_base + stride * idx_ext;
        regs_addr   = frame_addr + stride - REG_SZ;
        shadow_addr = shadow_off + encl_base + (idx_ext << SL_SHIFT);
    end
endmodule

// File: rtl/fs_target_sel.sv
// Resume target selection and target legality check.
// Notify path enters at the relocated entry point; the plain path resumes
// at the saved pointer. 64-bit mode requires a canonical target of VA_BITS,
// 32-bit mode requires the target not to exceed the code limit.
module fs_target_sel #(
    parameter int AW      = 64,
    parameter int LW      = 32,
    parameter int VA_BITS = 48
) (
    input  logic          notify_en,
    input  logic [7:0]    notify_byte,
    input  logic [AW-1:0] entry_off,
    input  logic [AW-1:0] encl_base,
    input  logic [AW-1:0] saved_ip,
    input  logic          mode64,
    input  logic [LW-1:0] cs_limit,
    output logic          notify,
    output logic [AW-1:0] target,
    output logic          target_bad
);
    localparam int HI_W = AW - VA_BITS + 1;

    logic [HI_W-1:0] upper;
    logic            canon;

    // Notify decision and target choice.
    always_comb begin
        notify = notify_en & notify_byte[0];
        target = notify ? (entry_off + encl_base) : saved_ip;
    end

    // Canonical form: the top bits from VA_BITS-1 upward all equal.
    always_comb begin
        upper = target[AW-1:VA_BITS-1];
        canon = (upper == '0) || (upper == '1);
        if (mode64) target_bad = !canon;
        else        target_bad = (target > AW'(cs_limit));
    end
endmodule

// File: rtl/fs_fault_prio.sv
// Fault priority encoder: reports the lowest-numbered applicable fault.
// Assumes each input is an independent fault condition of the request.
module fs_fault_prio
    import frame_stack_pkg::*;
(
    input  logic        no_frame,
    input  logic        no_room,
    input  logic        tgt_bad,
    input  logic        misalign,
    output logic        fault,
    output fault_code_e code
);
    // Priority chain, lowest code first.
    always_comb begin
        if (no_frame)      code = FC_NO_FRAME;
        else if (no_room)  code = FC_NO_ROOM;
        else if (tgt_bad)  code = FC_TARGET;
        else if (misalign) code = FC_MISALIGN;
        else               code = FC_NONE;
        fault = (code != FC_NONE);
    end
endmodule

// File: rtl/frame_stack_mgr.sv
// Save-frame stack manager top: on a start pulse computes the selected
// frame, register area, shadow slot and resume target, checks faults and
// registers everything; results are valid one cycle later and held.
// Assumes start is a single-cycle pulse with operands stable in that cycle.
module frame_stack_mgr
    import frame_stack_pkg::*;
#(
    parameter int REG_AREA_BYTES = 184,
    parameter int VA_BITS        = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  area_off,
    input  logic [ADDR_W-1:0]  encl_base,
    input  logic [PAGES_W-1:0] frame_pages,
    input  logic [IDX_W-1:0]   cur_idx,
    input  logic [IDX_W-1:0]   frame_cnt,
    input  logic               notify_en,
    input  logic [7:0]         notify_byte,
    input  logic [ADDR_W-1:0]  entry_off,
    input  logic [ADDR_W-1:0]  saved_ip,
    input  logic [ADDR_W-1:0]  shadow_off,
    input  logic               mode64,
    input  logic [31:0]        cs_limit,
    output logic               done,
    output logic               fault,
    output logic [2:0]         fault_code,
    output logic               notify_taken,
    output logic [ADDR_W-1:0]  frame_addr,
    output logic [ADDR_W-1:0]  regs_addr,
    output logic [ADDR_W-1:0]  shadow_addr,
    output logic [ADDR_W-1:0]  target,
    output logic [IDX_W-1:0]   new_idx,
    output logic               idx_we,
    output logic [IDX_W-1:0]   ret_idx
);
    localparam logic [SLOT_SHIFT-1:0] SLOT_MASK = '1;

    logic              nfy;
    logic [ADDR_W-1:0] tgt_c;
    logic              tgt_bad;
    logic [IDX_W-1:0]  idx_dec;
    logic [IDX_W-1:0]  slot_idx;
    logic [ADDR_W-1:0] frame_c, regs_c, shadow_c;
    logic              no_frame, no_room, misalign;
    logic              fault_c;
    fault_code_e       code_c;

    fs_target_sel #(.AW(ADDR_W), .LW(32), .VA_BITS(VA_BITS)) u_tgt (
        .notify_en  (notify_en),
        .notify_byte(notify_byte),
        .entry_off  (entry_off),
        .encl_base  (encl_base),
        .saved_ip   (saved_ip),
        .mode64     (mode64),
        .cs_limit   (cs_limit),
        .notify     (nfy),
        .target     (tgt_c),
        .target_bad (tgt_bad)
    );

    // Slot/frame factor: current index on notify, index minus one on pop.
    always_comb begin
        idx_dec  = cur_idx - IDX_W'(1);
        slot_idx = nfy ? cur_idx : idx_dec;
    end

    fs_addr_calc #(
        .AW(ADDR_W), .IW(IDX_W), .PW(PAGES_W), .PG_SHIFT(PAGE_SHIFT),
        .SL_SHIFT(SLOT_SHIFT), .REG_BYTES(REG_AREA_BYTES)
    ) u_addr (
        .area_off   (area_off),
        .encl_base  (encl_base),
        .frame_pages(frame_pages),
        .slot_idx   (slot_idx),
        .shadow_off (shadow_off),
        .frame_addr (frame_c),
        .regs_addr  (regs_c),
        .shadow_addr(shadow_c)
    );

    // Raw fault conditions.
    always_comb begin
        no_frame = (cur_idx == '0);
        no_room  = nfy && (cur_idx >= frame_cnt);
        misalign = (shadow_off[SLOT_SHIFT-1:0] & SLOT_MASK) != '0;
    end

    fs_fault_prio u_prio (
        .no_frame(no_frame),
        .no_room (no_room),
        .tgt_bad (tgt_bad),
        .misalign(misalign),
        .fault   (fault_c),
        .code    (code_c)
    );

    // Control outputs: done/strobe pulses and fault status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            idx_we     <= 1'b0;
            fault      <= 1'b0;
            fault_code <= 3'd0;
        end else begin
            done   <= start;
            idx_we <= start && !fault_c;
            if (start) begin
                fault      <= fault_c;
                fault_code <= code_c;
            end
        end
    end

    // Data outputs: captured on start, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notify_taken <= 1'b0;
            frame_addr   <= '0;
            regs_addr    <= '0;
            shadow_addr  <= '0;
            target       <= '0;
            new_idx      <= '0;
            ret_idx      <= '0;
        end else if (start) begin
            notify_taken <= nfy;
            frame_addr   <= frame_c;
            regs_addr    <= regs_c;
            shadow_addr  <= shadow_c;
            target       <= tgt_c;
            new_idx      <= nfy ? cur_idx : idx_dec;
            ret_idx      <= nfy ? cur_idx : '0;
        end
    end

    // Write-back strobe never coexists with a fault.
    assert_we_clean_R13: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |-> (!fault && done));

    // Result follows a start exactly one cycle later.
    assert_done_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // Zero index always faults with the no-frame code.
    assert_zero_idx_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cur_idx == '0) |=> (fault && fault_code == 3'd1));

    // A notify result that is written back had a free frame.
    assert_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && notify_en && notify_byte[0] && cur_idx >= frame_cnt) |=> fault);

    // A pop write-back is one below the sampled index.
    assert_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_we && !notify_taken) |-> (new_idx + 32'd1 == $past(cur_idx)));

    // Notification needs both the enable and bit 0 of the byte.
    assert_notify_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !(notify_en && notify_byte[0])) |=> !notify_taken);
endmodule

// File: tb/tb_frame_stack_mgr.sv
// Sweep bench: index/count/pages/notify grid plus directed fault cases.
module tb_frame_stack_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] area_off = '0, encl_base = '0, entry_off = '0;
    logic [63:0] saved_ip = '0, shadow_off = '0;
    logic [15:0] frame_pages = '0;
    logic [31:0] cur_idx = '0, frame_cnt = '0, cs_limit = '0;
    logic        notify_en = 1'b0, mode64 = 1'b1;
    logic [7:0]  notify_byte = '0;
    logic        done, fault, notify_taken, idx_we;
    logic [2:0]  fault_code;
    logic [63:0] frame_addr, regs_addr, shadow_addr, target;
    logic [31:0] new_idx, ret_idx;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    frame_stack_mgr dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .area_off(area_off), .encl_base(encl_base), .frame_pages(frame_pages),
        .cur_idx(cur_idx), .frame_cnt(frame_cnt), .notify_en(notify_en),
        .notify_byte(notify_byte), .entry_off(entry_off), .saved_ip(saved_ip),
        .shadow_off(shadow_off), .mode64(mode64), .cs_limit(cs_limit),
        .done(done), .fault(fault), .fault_code(fault_code),
        .notify_taken(notify_taken), .frame_addr(frame_addr),
        .regs_addr(regs_addr), .shadow_addr(shadow_addr), .target(target),
        .new_idx(new_idx), .idx_we(idx_we), .ret_idx(ret_idx)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit canon48(input logic [63:0] t);
        return (t >> 47) == 64'd0 || (t >> 47) == 64'h1ffff;
    endfunction

    // Apply one request and compare every output against the model.
    task automatic run_one(input string tag);
        bit          nf;
        logic [31:0] k;
        logic [63:0] st, fa, tg;
        int          code;
        nf = notify_en && notify_byte[0];
        k  = nf ? cur_idx : cur_idx - 32'd1;
        st = 64'(frame_pages) * 64'd4096;
        fa = area_off + encl_base + st * 64'(k);
        tg = nf ? entry_off + encl_base : saved_ip;
        if (cur_idx == 0) code = 1;
        else if (nf && cur_idx >= frame_cnt) code = 2;
        else if (mode64 ? !canon48(tg) : (tg > 64'(cs_limit))) code = 3;
        else if (shadow_off % 16 != 0) code = 4;
        else code = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R13 done"}, 64'(done), 64'd1);
        chk({tag, " R12 fault_code"}, 64'(fault_code), 64'(code));
        chk({tag, " R12 fault"}, 64'(fault), 64'(code != 0));
        chk({tag, " R13 idx_we"}, 64'(idx_we), 64'(code == 0));
        chk({tag, " R4 notify"}, 64'(notify_taken), 64'(nf));
        if (cur_idx != 0) begin
            chk({tag, " R2/R6 frame_addr"}, frame_addr, fa);
            chk({tag, " R3 regs_addr"}, regs_addr, fa + st - 64'd184);
            chk({tag, " R8 shadow_addr"}, shadow_addr, shadow_off + encl_base + 64'(k) * 64'd16);
            chk({tag, " R6/R7 target"}, target, tg);
            chk({tag, " R6/R7 new_idx"}, 64'(new_idx), 64'(nf ? cur_idx : cur_idx - 32'd1));
            chk({tag, " R6/R7 ret_idx"}, 64'(ret_idx), 64'(nf ? cur_idx : 32'd0));
        end
        @(negedge clk);
        chk({tag, " R13 done drops"}, 64'(done), 64'd0);
        chk({tag, " R13 hold"}, 64'(fault_code), 64'(code));
    endtask

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R13 reset done", 64'(done), 64'd0);
        chk("R13 reset fault", 64'(fault), 64'd0);
        chk("R13 reset idx_we", 64'(idx_we), 64'd0);
        chk("R13 reset code", 64'(fault_code), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        area_off   = 64'h2000;
        encl_base  = 64'h0000_7f00_0000_0000;
        entry_off  = 64'h100;
        saved_ip   = 64'h0000_7f00_0000_5abc;
        shadow_off = 64'h30;
        mode64     = 1'b1;
        // Main sweep (R1, R2, R3, R4, R5, R6, R7, R8).
        for (int p = 1; p <= 3; p++)
            for (int i = 0; i <= 4; i++)
                for (int c = 0; c <= 4; c++)
                    for (int m = 0; m < 4; m++) begin
                        frame_pages = 16'(p);
                        cur_idx     = 32'(i);
                        frame_cnt   = 32'(c);
                        notify_en   = m[0];
                        notify_byte = m[1] ? 8'h01 : 8'hFE;
                        run_one("sweep");
                    end

        // R4: other byte bits ignored, enable alone insufficient.
        frame_pages = 16'd2; cur_idx = 32'd3; frame_cnt = 32'd8;
        notify_en = 1'b1; notify_byte = 8'hFE; run_one("R4 byte-bit0-clear");
        notify_en = 1'b0; notify_byte = 8'hFF; run_one("R4 enable-clear");
        // Large pages, wraparound arithmetic (R2).
        frame_pages = 16'hFFFF; encl_base = 64'hFFFF_FFFF_FFFF_0000;
        notify_en = 1'b0; saved_ip = 64'h1000; run_one("R2 wrap");
        encl_base = 64'h0000_7f00_0000_0000;
        frame_pages = 16'd1;

        // R10: non-canonical saved pointer in 64-bit mode.
        saved_ip = 64'h0000_8000_0000_0000; run_one("R10 noncanon");
        saved_ip = 64'hFFFF_8000_0000_0000; run_one("R10 canon-high");
        // R11: 32-bit mode limit check.
        mode64 = 1'b0; cs_limit = 32'h0000_FFFF;
        saved_ip = 64'h0000_FFFF; run_one("R11 at-limit");
        saved_ip = 64'h0001_0000; run_one("R11 above-limit");
        mode64 = 1'b1; saved_ip = 64'h0000_7f00_0000_5abc;
        // R9: misaligned shadow offset.
        shadow_off = 64'h38; run_one("R9 misalign");
        shadow_off = 64'h40; run_one("R9 aligned");

        // R12: simultaneous faults on the notify path.
        notify_en = 1'b1; notify_byte = 8'h01;
        cur_idx = 32'd4; frame_cnt = 32'd4;
        entry_off = 64'h0000_8000_0000_0000; encl_base = 64'h0;
        shadow_off = 64'h3; run_one("R12 room+target+align");
        cur_idx = 32'd2; run_one("R12 target+align");
        entry_off = 64'h100; run_one("R12 align-only");
        cur_idx = 32'd0; run_one("R12 zero-over-all");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule